// File: doc/BRIEF.md
# Instruction Packet Slot Legality Checker

This block screens a candidate issue packet before it enters a four-slot wide-issue pipeline. Each packet entry carries a valid bit and a 3-bit instruction class. The checker gives every valid entry an issue slot, taking the entries in input order. It also counts the entries that compete for the shared vector store port and for the two vector multiply units. From this it reports whether the packet can issue, which slot each entry landed in, and a code for the most important violation.

The decision logic is purely combinational. A parameter selects whether the results leave the block directly or through one register stage. The number of candidate entries is a parameter and may exceed the slot count, so that oversized packets can be flagged. The slot count is fixed at four.

Top module: `pkt_slot_check`

## Requirements
- R1: With REG_OUT=1, while reset is asserted and until the first clock edge after release, `legal_o`, `err_o`, `slot_o` and `placed_o` are all zero.
- R2: Class codes are 0 general ALU, 1 logical, 2 scalar multiply, 3 load, 4 scalar store, 5 vector store, 6 single-unit vector multiply, 7 dual-unit vector multiply. Logical and scalar multiply may use only slots 2 and 3. Load and scalar store may use only slots 0 and 1. All other classes may use any slot.
- R3: Entries are placed in increasing index order. Each valid entry takes the lowest-numbered slot that is still free and allowed for its class. `placed_o[i]` is set when entry i got a slot, and its slot number is in `slot_o[2*i+1:2*i]`.
- R4: No two placed entries report the same slot.
- R5: More than four valid entries gives error code 1. This code has the highest priority.
- R6: A valid entry that finds no free allowed slot gives error code 2. That entry is left unplaced, and later entries still try to place.
- R7: Two or more vector stores in one packet give error code 3. Any number of scalar stores that fit in their slots is legal.
- R8: A single-unit vector multiply uses one multiply unit and a dual-unit one uses two. Demand above two units gives error code 4. This code has the lowest priority.
- R9: `legal_o` is 1 exactly when `err_o` is 0.
- R10: With REG_OUT=0 the outputs follow the inputs in the same cycle. With REG_OUT=1 they show the result for the inputs sampled at the previous rising clock edge.
- R11: Entries whose valid bit is clear are ignored. They report `placed_o` 0 and slot 0, and they do not change the placement or the error code of any other entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | N_ENT | Per-entry valid bits |
| cls_i | input | 3*N_ENT | Per-entry class codes, entry i at bits 3i+2:3i |
| legal_o | output | 1 | Packet may issue |
| err_o | output | 3 | Highest-priority violation code |
| slot_o | output | 2*N_ENT | Assigned slot per entry |
| placed_o | output | N_ENT | Entry received a slot |

## Verification
The bench builds two copies of the block, both with N_ENT=6. One has REG_OUT=1 and one has REG_OUT=0, so both the registered timing and the same-cycle timing are compared against one behavioural model. Six entries make oversize packets of five and six instructions reachable, and those packets exercise the top-priority count error. With the extra entries, a packet can also carry a mix of slot conflicts and vector-resource conflicts at the same time, which tests the error priority order.

// File: rtl/pkt_slot_pkg.sv
package pkt_slot_pkg;
  localparam int SLOTS  = 4;
  localparam int SLOT_W = 2;
  localparam int CLS_W  = 3;

  typedef enum logic [CLS_W-1:0] {
    CL_ALU    = 3'd0,
    CL_LOGIC  = 3'd1,
    CL_MUL    = 3'd2,
    CL_LOAD   = 3'd3,
    CL_STORE  = 3'd4,
    CL_VSTORE = 3'd5,
    CL_VMUL1  = 3'd6,
    CL_VMUL2  = 3'd7
  } icls_e;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_COUNT = 3'd1,
    ERR_SLOT  = 3'd2,
    ERR_VST   = 3'd3,
    ERR_VMUL  = 3'd4
  } perr_e;

  // Slots a class may occupy, bit s set when slot s is allowed.
  function automatic logic [SLOTS-1:0] slot_mask(logic [CLS_W-1:0] c);
    case (c)
      CL_LOGIC, CL_MUL:  slot_mask = 4'b1100;
      CL_LOAD, CL_STORE: slot_mask = 4'b0011;
      default:           slot_mask = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/pkt_slot_alloc.sv
module pkt_slot_alloc
  import pkt_slot_pkg::*;
#(
  parameter int N_ENT = 6
) (
  input  logic [N_ENT-1:0]        valid_i,
  input  logic [N_ENT*CLS_W-1:0]  cls_i,
  output logic [N_ENT*SLOT_W-1:0] slot_o,
  output logic [N_ENT-1:0]        placed_o,
  output logic                    conflict_o
);
  logic [SLOTS-1:0] free_chain [0:N_ENT];
  logic [N_ENT-1:0] miss;

  assign free_chain[0] = '1;

  for (genvar gi = 0; gi < N_ENT; gi++) begin : g_ent
    logic [SLOTS-1:0]  cand;
    logic [SLOTS-1:0]  take;
    logic [SLOT_W-1:0] idx;
    logic              hit;

    assign cand = valid_i[gi] ? (slot_mask(cls_i[gi*CLS_W +: CLS_W]) & free_chain[gi]) : '0;

    always_comb begin
      take = '0;
      idx  = '0;
      hit  = 1'b0;
      for (int s = SLOTS-1; s >= 0; s--) begin
        if (cand[s]) begin
          take = '0;
          take[s] = 1'b1;
          idx  = SLOT_W'(s);
          hit  = 1'b1;
        end
      end
    end

    assign free_chain[gi+1]           = free_chain[gi] & ~take;
    assign slot_o[gi*SLOT_W +: SLOT_W] = idx;
    assign placed_o[gi]               = hit;
    assign miss[gi]                   = valid_i[gi] & ~hit;
  end

  assign conflict_o = |miss;
endmodule

// File: rtl/pkt_vec_res.sv
module pkt_vec_res
  import pkt_slot_pkg::*;
#(
  parameter int N_ENT  = 6,
  parameter int VMUL_U = 2
) (
  input  logic [N_ENT-1:0]       valid_i,
  input  logic [N_ENT*CLS_W-1:0] cls_i,
  output logic                   vst_over_o,
  output logic                   vmul_over_o
);
  localparam int CNT_W = $clog2(2*N_ENT+1) + 1;

  logic [CNT_W-1:0] vst_cnt;
  logic [CNT_W-1:0] vmul_cnt;

  always_comb begin
    vst_cnt  = '0;
    vmul_cnt = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (valid_i[i]) begin
        case (cls_i[i*CLS_W +: CLS_W])
          CL_VSTORE: vst_cnt  = vst_cnt + 1'b1;
          CL_VMUL1:  vmul_cnt = vmul_cnt + CNT_W'(1);
          CL_VMUL2:  vmul_cnt = vmul_cnt + CNT_W'(2);
          default:   ;
        endcase
      end
    end
  end

  assign vst_over_o  = vst_cnt > CNT_W'(1);
  assign vmul_over_o = vmul_cnt > CNT_W'(VMUL_U);
endmodule

// File: rtl/pkt_slot_check.sv
module pkt_slot_check
  import pkt_slot_pkg::*;
#(
  parameter int N_ENT   = 6,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_ENT-1:0]        valid_i,
  input  logic [N_ENT*CLS_W-1:0]  cls_i,
  output logic                    legal_o,
  output logic [2:0]              err_o,
  output logic [N_ENT*SLOT_W-1:0] slot_o,
  output logic [N_ENT-1:0]        placed_o
);
  localparam int POP_W = $clog2(N_ENT+1);

  logic [N_ENT*SLOT_W-1:0] slot_c;
  logic [N_ENT-1:0]        placed_c;
  logic                    conflict_c;
  logic                    vst_over_c;
  logic                    vmul_over_c;
  logic [POP_W-1:0]        n_valid;
  perr_e                   err_c;
  logic                    legal_c;

  pkt_slot_alloc #(.N_ENT(N_ENT)) u_alloc (
    .valid_i    (valid_i),
    .cls_i      (cls_i),
    .slot_o     (slot_c),
    .placed_o   (placed_c),
    .conflict_o (conflict_c)
  );

  pkt_vec_res #(.N_ENT(N_ENT), .VMUL_U(2)) u_res (
    .valid_i     (valid_i),
    .cls_i       (cls_i),
    .vst_over_o  (vst_over_c),
    .vmul_over_o (vmul_over_c)
  );

  always_comb begin
    n_valid = '0;
    for (int i = 0; i < N_ENT; i++) n_valid = n_valid + POP_W'(valid_i[i]);
  end

  always_comb begin
    if (32'(n_valid) > SLOTS) err_c = ERR_COUNT;
    else if (conflict_c)      err_c = ERR_SLOT;
    else if (vst_over_c)      err_c = ERR_VST;
    else if (vmul_over_c)     err_c = ERR_VMUL;
    else                      err_c = ERR_NONE;
  end

  assign legal_c = (err_c == ERR_NONE);

  if (REG_OUT) begin : g_reg
    logic                    legal_q, legal_d;
    logic [2:0]              err_q, err_d;
    logic [N_ENT*SLOT_W-1:0] slot_q, slot_d;
    logic [N_ENT-1:0]        placed_q, placed_d;

    always_comb begin
      legal_d  = legal_c;
      err_d    = err_c;
      slot_d   = slot_c;
      placed_d = placed_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        legal_q  <= 1'b0;
        err_q    <= '0;
        slot_q   <= '0;
        placed_q <= '0;
      end else begin
        legal_q  <= legal_d;
        err_q    <= err_d;
        slot_q   <= slot_d;
        placed_q <= placed_d;
      end
    end

    assign legal_o  = legal_q;
    assign err_o    = err_q;
    assign slot_o   = slot_q;
    assign placed_o = placed_q;
  end else begin : g_comb
    assign legal_o  = legal_c;
    assign err_o    = err_c;
    assign slot_o   = slot_c;
    assign placed_o = placed_c;
  end

  // Checks on the combinational decision, sampled at each edge.
  for (genvar ai = 0; ai < N_ENT; ai++) begin : g_chk
    assert_slot_allowed_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      placed_c[ai] |-> slot_mask(cls_i[ai*CLS_W +: CLS_W])[slot_c[ai*SLOT_W +: SLOT_W]]);
    for (genvar aj = ai + 1; aj < N_ENT; aj++) begin : g_pair
      assert_no_shared_slot_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (placed_c[ai] && placed_c[aj]) |->
          (slot_c[ai*SLOT_W +: SLOT_W] != slot_c[aj*SLOT_W +: SLOT_W]));
    end
  end

  assert_idle_unplaced_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    (placed_c & ~valid_i) == '0);

  assert_all_placed_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (!conflict_c && 32'(n_valid) <= SLOTS) |-> ($countones(placed_c) == $countones(valid_i)));

  assert_vmul_lowest_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (err_c == ERR_VMUL) |-> (vmul_over_c && !vst_over_c && !conflict_c));
endmodule

// File: tb/pkt_slot_check_tb_top.sv
module pkt_slot_check_tb_top;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0]   valid;
  logic [N*3-1:0] cls;

  logic           r_legal, c_legal;
  logic [2:0]     r_err, c_err;
  logic [N*2-1:0] r_slot, c_slot;
  logic [N-1:0]   r_placed, c_placed;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pkt_slot_check #(.N_ENT(N), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid), .cls_i(cls),
    .legal_o(r_legal), .err_o(r_err), .slot_o(r_slot), .placed_o(r_placed));

  pkt_slot_check #(.N_ENT(N), .REG_OUT(1'b0)) dut_comb_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid), .cls_i(cls),
    .legal_o(c_legal), .err_o(c_err), .slot_o(c_slot), .placed_o(c_placed));

  function automatic int allow(int c, int s);
    if (c == 1 || c == 2) return (s >= 2) ? 1 : 0;
    if (c == 3 || c == 4) return (s <= 1) ? 1 : 0;
    return 1;
  endfunction

  function automatic void model(input logic [N-1:0] v, input logic [N*3-1:0] c,
                                output logic lg, output logic [2:0] er,
                                output logic [N*2-1:0] sl, output logic [N-1:0] pl);
    int used[4];
    int cnt = 0, vst = 0, vmu = 0;
    bit miss = 0;
    for (int s = 0; s < 4; s++) used[s] = 0;
    sl = '0; pl = '0;
    for (int i = 0; i < N; i++) begin
      int ci = int'(c[i*3 +: 3]);
      if (v[i]) begin
        bit got = 0;
        cnt++;
        if (ci == 5) vst++;
        if (ci == 6) vmu += 1;
        if (ci == 7) vmu += 2;
        for (int s = 0; s < 4; s++) begin
          if (!got && used[s] == 0 && allow(ci, s) == 1) begin
            used[s] = 1; got = 1; pl[i] = 1'b1; sl[i*2 +: 2] = 2'(s);
          end
        end
        if (!got) miss = 1;
      end
    end
    if (cnt > 4)      er = 3'd1;
    else if (miss)    er = 3'd2;
    else if (vst > 1) er = 3'd3;
    else if (vmu > 2) er = 3'd4;
    else              er = 3'd0;
    lg = (er == 3'd0);
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [N-1:0] v, input logic [N*3-1:0] c);
    logic lg; logic [2:0] er; logic [N*2-1:0] sl; logic [N-1:0] pl;
    model(v, c, lg, er, sl, pl);
    @(negedge clk);
    valid = v; cls = c;
    #1;
    // R10: same-cycle view
    cmp({tag, "/R10comb"}, "legal",  32'(c_legal),  32'(lg));
    cmp({tag, "/R10comb"}, "err",    32'(c_err),    32'(er));
    cmp({tag, "/R10comb"}, "slot",   32'(c_slot),   32'(sl));
    cmp({tag, "/R10comb"}, "placed", 32'(c_placed), 32'(pl));
    @(posedge clk); #1;
    // R10: registered view one edge later
    cmp({tag, "/R10reg"}, "legal",  32'(r_legal),  32'(lg));
    cmp({tag, "/R10reg"}, "err",    32'(r_err),    32'(er));
    cmp({tag, "/R10reg"}, "slot",   32'(r_slot),   32'(sl));
    cmp({tag, "/R10reg"}, "placed", 32'(r_placed), 32'(pl));
  endtask

  function automatic logic [N*3-1:0] pk(int a, int b, int c, int d, int e, int f);
    return {3'(f), 3'(e), 3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction

  initial begin : watchdog
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    valid = 6'b101101;
    cls   = pk(1, 3, 7, 5, 5, 2);
    repeat (3) @(posedge clk);
    #1;
    // R1: registered outputs held at zero in reset
    cmp("R1", "legal",  32'(r_legal),  0);
    cmp("R1", "err",    32'(r_err),    0);
    cmp("R1", "slot",   32'(r_slot),   0);
    cmp("R1", "placed", 32'(r_placed), 0);
    @(negedge clk);
    rst_n = 1'b1;

    apply("R2_alu4",     6'b001111, pk(0, 0, 0, 0, 0, 0));
    apply("R2_logic_mul",6'b000011, pk(1, 2, 0, 0, 0, 0));
    apply("R2_loads",    6'b000111, pk(3, 3, 0, 0, 0, 0));
    apply("R3_greedy",   6'b001111, pk(0, 3, 1, 0, 0, 0));
    apply("R3_order",    6'b001111, pk(1, 0, 3, 0, 0, 0));
    apply("R6_3logic",   6'b000111, pk(1, 2, 1, 0, 0, 0));
    apply("R6_greedyblk",6'b000111, pk(0, 0, 3, 0, 0, 0));
    apply("R6_later",    6'b001111, pk(3, 4, 3, 1, 0, 0));
    apply("R7_scalar_st",6'b000011, pk(4, 4, 0, 0, 0, 0));
    apply("R7_two_vst",  6'b000011, pk(5, 5, 0, 0, 0, 0));
    apply("R8_two_single",6'b000011, pk(6, 6, 0, 0, 0, 0));
    apply("R8_dbl_single",6'b000011, pk(7, 6, 0, 0, 0, 0));
    apply("R8_two_dbl",  6'b000011, pk(7, 7, 0, 0, 0, 0));
    apply("R8_three_sgl",6'b000111, pk(6, 6, 6, 0, 0, 0));
    apply("R5_five",     6'b011111, pk(0, 0, 0, 0, 0, 0));
    apply("R5_prio",     6'b111111, pk(5, 5, 1, 1, 1, 7));
    apply("R9_slot_over_vst", 6'b001111, pk(5, 5, 3, 3, 3, 0));
    apply("R9_vst_over_vmul", 6'b000111, pk(5, 5, 7, 0, 0, 0));
    apply("R11_holes",   6'b101001, pk(1, 1, 1, 3, 1, 3));
    apply("R11_empty",   6'b000000, pk(7, 7, 5, 5, 1, 1));
    apply("R11_idle_cls",6'b010010, pk(5, 1, 5, 5, 2, 5));

    for (int k = 0; k < 400; k++) begin
      logic [N-1:0]   rv;
      logic [N*3-1:0] rc;
      rv = N'($urandom);
      if (k % 3 != 0) rv[5:4] = 2'b00;
      rc = (N*3)'($urandom);
      apply("R3_random", rv, rc);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule